// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns a floating-point operand that has already been unpacked into a signed two's-complement integer. The operand arrives as a sign, a class code, a signed unbiased exponent and a normalized significand. The significand's most significant bit carries weight 2^0. Guard, round and sticky bits extend the significand below its least significant bit. The conversion always truncates toward zero. No rounding-mode input exists, and none is consulted.

Two flags come with the integer. Inexact is set when some fraction bit is dropped. Invalid is set when the value cannot be represented, or when the operand is not a number. An invalid result saturates by sign and is never reported as inexact. The integer width is a parameter, 32 by default, and 64 is equally valid. The overflow limit is 2^(WIDTH-1), and the most negative integer is accepted. One operand can be presented per cycle. Each result appears one register stage later.

Top module: `f2i_trunc_conv`

## Requirements
- R1: Every cycle with `in_valid` high is followed, on the next rising edge, by exactly one cycle of `out_valid` high carrying that operand's result. A cycle with `in_valid` low is followed by `out_valid` low.
- R2: Class code 0 (zero) gives result 0 with both flags low, whatever the sign, exponent and significand are.
- R3: A class 1 (number) operand with exponent 0 to WIDTH-1 whose magnitude is in range gives the integer part of its magnitude, truncated toward zero. When the sign is set, that integer part is negated in two's complement.
- R4: For a class 1 result that is not invalid, inexact is high exactly when a dropped bit is nonzero. The dropped bits are the significand bits below the binary point, guard, round and sticky.
- R5: A class 1 operand with a negative exponent gives result 0 and invalid low. Its inexact flag is high when any significand, guard, round or sticky bit is set.
- R6: A class 1 operand with exponent WIDTH or greater is invalid, whatever its significand is.
- R7: A truncated magnitude above 2^(WIDTH-1) is invalid for either sign. A magnitude equal to 2^(WIDTH-1) is invalid when the sign is clear. When the sign is set, that same magnitude is valid and gives the most negative integer.
- R8: Class codes 2 (infinity), 3 (quiet NaN) and 4 (signalling NaN) are invalid, and so are the unused codes 5 to 7.
- R9: An invalid result has inexact low. It equals 2^(WIDTH-1)-1 when the sign is clear, and -2^(WIDTH-1) when the sign is set.
- R10: After reset, `out_valid`, the result and both flags are 0. While `in_valid` is low, the result and the flags keep their last values, and no other input changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_cls | input | 3 | Class code: 0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_sig | input | SIG_W | Normalized significand, MSB weight 2^0 |
| in_guard | input | 1 | First bit below the significand |
| in_round | input | 1 | Second bit below the significand |
| in_sticky | input | 1 | OR of all lower bits |
| out_valid | output | 1 | Result present this cycle |
| out_result | output | WIDTH | Two's-complement integer |
| out_inexact | output | 1 | Fraction bits were dropped |
| out_invalid | output | 1 | Out of range or not a number |

## Verification
Every result is due exactly one rising edge after the cycle that presents its operand. Operands are driven on falling edges and may come back to back. The driver stamps each expected entry with the cycle count at which the matching output must appear. The monitor samples on the following falling edge and fails any entry that is early, late or unclaimed. After the last operand, the inputs are scrambled with `in_valid` held low for several cycles. The held outputs are then compared with the last expected entry.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;

   typedef enum logic [2:0] {
      FC_ZERO = 3'd0,
      FC_NUM  = 3'd1,
      FC_INF  = 3'd2,
      FC_QNAN = 3'd3,
      FC_SNAN = 3'd4
   } fclass_e;

endpackage

// File: rtl/f2i_align.sv
`timescale 1ns/1ps
// Places the integer part of the significand in a WIDTH-bit field by a
// logarithmic left shift of {sig, guard, round} by the exponent.
module f2i_align #(
   parameter int WIDTH = 32,
   parameter int SIG_W = 64,
   parameter int EXP_W = 16
) (
   input  logic                    [SIG_W-1:0] sig,
   input  logic                                guard,
   input  logic                                rnd,
   input  logic                                sticky,
   input  logic signed             [EXP_W-1:0] exp_i,
   output logic                    [WIDTH-1:0] mag,
   output logic                                lost,
   output logic                                big
);
   localparam int SH_W    = $clog2(WIDTH);
   localparam int FRAC_W  = SIG_W + 1;
   localparam int FIELD_W = FRAC_W + WIDTH;
   localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(WIDTH);

   logic [FIELD_W-1:0] stg [SH_W+1];
   logic [SH_W-1:0]    amt;
   logic               neg;

   assign amt    = exp_i[SH_W-1:0];
   assign neg    = exp_i < 0;
   assign big    = exp_i >= EXP_LIM;
   assign stg[0] = {{(WIDTH-1){1'b0}}, sig, guard, rnd};

   generate
      for (genvar k = 0; k < SH_W; k++) begin : g_stage
         localparam int STEP = 1 << k;
         assign stg[k+1] = amt[k] ? {stg[k][FIELD_W-1-STEP:0], {STEP{1'b0}}}
                                  : stg[k];
      end
   endgenerate

   always_comb begin
      if (neg) begin
         mag  = '0;
         lost = (|sig) | guard | rnd | sticky;
      end else begin
         mag  = stg[SH_W][FIELD_W-1 -: WIDTH];
         lost = (|stg[SH_W][FRAC_W-1:0]) | sticky;
      end
   end
endmodule

// File: rtl/f2i_limit.sv
`timescale 1ns/1ps
// Range check, sign application and saturation.
module f2i_limit #(
   parameter int WIDTH = 32
) (
   input  logic             sign,
   input  logic [2:0]       cls,
   input  logic [WIDTH-1:0] mag,
   input  logic             lost,
   input  logic             big,
   output logic [WIDTH-1:0] res,
   output logic             inexact,
   output logic             invalid
);
   import f2i_pkg::*;

   localparam logic [WIDTH-1:0] EDGE = {1'b1, {(WIDTH-1){1'b0}}};

   logic is_zero, is_num, over;

   assign is_zero = (cls == FC_ZERO);
   assign is_num  = (cls == FC_NUM);
   assign over    = big || (mag > EDGE) || ((mag == EDGE) && !sign);

   always_comb begin
      if (is_zero) begin
         res     = '0;
         inexact = 1'b0;
         invalid = 1'b0;
      end else if (!is_num || over) begin
         res     = sign ? EDGE : ~EDGE;
         inexact = 1'b0;
         invalid = 1'b1;
      end else begin
         res     = sign ? (~mag + 1'b1) : mag;
         inexact = lost;
         invalid = 1'b0;
      end
   end
endmodule

// File: rtl/f2i_trunc_conv.sv
`timescale 1ns/1ps
module f2i_trunc_conv #(
   parameter int WIDTH = 32,
   parameter int SIG_W = 64,
   parameter int EXP_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_sign,
   input  logic [2:0]              in_cls,
   input  logic signed [EXP_W-1:0] in_exp,
   input  logic [SIG_W-1:0]        in_sig,
   input  logic                    in_guard,
   input  logic                    in_round,
   input  logic                    in_sticky,
   output logic                    out_valid,
   output logic [WIDTH-1:0]        out_result,
   output logic                    out_inexact,
   output logic                    out_invalid
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("f2i_trunc_conv: WIDTH must be at least 2");
      end
      if (SIG_W < 2) begin : g_bad_sig
         $error("f2i_trunc_conv: SIG_W must be at least 2");
      end
      if (EXP_W < $clog2(WIDTH) + 2) begin : g_bad_exp
         $error("f2i_trunc_conv: EXP_W too narrow to reach WIDTH");
      end
   endgenerate

   logic [WIDTH-1:0] mag, nxt_res;
   logic             lost, big, nxt_inx, nxt_inv;

   f2i_align #(.WIDTH(WIDTH), .SIG_W(SIG_W), .EXP_W(EXP_W)) u_align (
      .sig    (in_sig),
      .guard  (in_guard),
      .rnd    (in_round),
      .sticky (in_sticky),
      .exp_i  (in_exp),
      .mag    (mag),
      .lost   (lost),
      .big    (big)
   );

   f2i_limit #(.WIDTH(WIDTH)) u_limit (
      .sign    (in_sign),
      .cls     (in_cls),
      .mag     (mag),
      .lost    (lost),
      .big     (big),
      .res     (nxt_res),
      .inexact (nxt_inx),
      .invalid (nxt_inv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_result  <= '0;
         out_inexact <= 1'b0;
         out_invalid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_result  <= nxt_res;
            out_inexact <= nxt_inx;
            out_invalid <= nxt_inv;
         end
      end
   end
endmodule

// File: rtl/f2i_trunc_conv_chk.sv
`timescale 1ns/1ps
module f2i_trunc_conv_chk #(
   parameter int WIDTH = 32,
   parameter int SIG_W = 64,
   parameter int EXP_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_sign,
   input logic [2:0]              in_cls,
   input logic signed [EXP_W-1:0] in_exp,
   input logic [SIG_W-1:0]        in_sig,
   input logic                    in_guard,
   input logic                    in_round,
   input logic                    in_sticky,
   input logic                    out_valid,
   input logic [WIDTH-1:0]        out_result,
   input logic                    out_inexact,
   input logic                    out_invalid
);
   localparam logic [WIDTH-1:0] MAXV = {1'b0, {(WIDTH-1){1'b1}}};
   localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};
   localparam logic signed [EXP_W-1:0] EXP_LIM = EXP_W'(WIDTH);

   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls == 3'd0) |=>
         (out_result == '0 && !out_inexact && !out_invalid));

   assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls == 3'd1) |=>
         (out_invalid || out_result == '0 || out_result[WIDTH-1] == $past(in_sign)));

   assert_negexp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls == 3'd1 && in_exp < 0) |=>
         (out_result == '0 && !out_invalid &&
          out_inexact == $past((|in_sig) | in_guard | in_round | in_sticky)));

   assert_bigexp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls == 3'd1 && in_exp >= EXP_LIM) |=>
         (out_invalid && out_result == ($past(in_sign) ? MINV : MAXV)));

   assert_nonnum_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_cls > 3'd1) |=>
         (out_invalid && !out_inexact && out_result == ($past(in_sign) ? MINV : MAXV)));

   assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_inexact && out_invalid));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_result) && $stable(out_inexact) && $stable(out_invalid)));
endmodule

bind f2i_trunc_conv f2i_trunc_conv_chk #(
   .WIDTH(WIDTH), .SIG_W(SIG_W), .EXP_W(EXP_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_sign     (in_sign),
   .in_cls      (in_cls),
   .in_exp      (in_exp),
   .in_sig      (in_sig),
   .in_guard    (in_guard),
   .in_round    (in_round),
   .in_sticky   (in_sticky),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .out_inexact (out_inexact),
   .out_invalid (out_invalid)
);

// File: tb/sim_f2i_trunc_conv.sv
`timescale 1ns/1ps
module sim_f2i_trunc_conv;
   localparam int WIDTH = 32;
   localparam int SIG_W = 64;
   localparam int EXP_W = 16;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic                    in_sign = 1'b0;
   logic [2:0]              in_cls = 3'd0;
   logic signed [EXP_W-1:0] in_exp = '0;
   logic [SIG_W-1:0]        in_sig = '0;
   logic                    in_guard = 1'b0;
   logic                    in_round = 1'b0;
   logic                    in_sticky = 1'b0;
   logic                    out_valid;
   logic [WIDTH-1:0]        out_result;
   logic                    out_inexact;
   logic                    out_invalid;

   always #10 clk = ~clk;

   f2i_trunc_conv #(.WIDTH(WIDTH), .SIG_W(SIG_W), .EXP_W(EXP_W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
      .in_cls(in_cls), .in_exp(in_exp), .in_sig(in_sig), .in_guard(in_guard),
      .in_round(in_round), .in_sticky(in_sticky), .out_valid(out_valid),
      .out_result(out_result), .out_inexact(out_inexact), .out_invalid(out_invalid)
   );

   typedef struct {
      logic [WIDTH-1:0] res;
      logic             inx;
      logic             inv;
      int               due;
      string            tag;
   } item_t;

   item_t sbq[$];
   item_t last_item;
   int    cyc = 0;
   int    n_chk = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // Reference model written from the requirements.
   function automatic item_t model(input logic sg, input logic [2:0] c, input int e,
                                   input logic [SIG_W-1:0] m, input logic g, r, s);
      item_t            x;
      logic [127:0]     mag;
      logic [127:0]     lim;
      logic [SIG_W-1:0] one;
      logic [SIG_W-1:0] mask;
      logic [WIDTH-1:0] lo;
      logic             lost;
      int               sh;
      lim   = 128'd1 << (WIDTH - 1);
      one   = 1;
      x.res = '0; x.inx = 1'b0; x.inv = 1'b0; x.due = 0; x.tag = "";
      if (c == 3'd0) return x;
      if (c == 3'd1 && e < WIDTH) begin
         if (e < 0) begin
            mag  = '0;
            lost = (|m) | g | r | s;
         end else begin
            sh = SIG_W - 1 - e;
            if (sh >= 0) begin
               mag  = 128'(m) >> sh;
               mask = (one << sh) - one;
               lost = ((m & mask) != '0) | g | r | s;
            end else begin
               mag  = 128'(m) << (-sh);
               lost = g | r | s;
            end
         end
         if (mag < lim || (mag == lim && sg)) begin
            lo    = mag[WIDTH-1:0];
            x.res = sg ? (WIDTH'(0) - lo) : lo;
            x.inx = lost;
            return x;
         end
      end
      x.inv = 1'b1;
      x.res = sg ? {1'b1, {(WIDTH-1){1'b0}}} : {1'b0, {(WIDTH-1){1'b1}}};
      return x;
   endfunction

   task automatic apply(input logic sg, input logic [2:0] c, input int e,
                        input logic [SIG_W-1:0] m, input logic g, r, s, input string tag);
      item_t it;
      @(negedge clk);
      in_valid  = 1'b1;
      in_sign   = sg;
      in_cls    = c;
      in_exp    = EXP_W'(e);
      in_sig    = m;
      in_guard  = g;
      in_round  = r;
      in_sticky = s;
      it        = model(sg, c, e, m, g, r, s);
      it.due    = cyc + 1;
      it.tag    = tag;
      sbq.push_back(it);
      last_item = it;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         in_valid  = 1'b0;
         in_sign   = ~in_sign;
         in_cls    = in_cls + 3'd1;
         in_exp    = in_exp + 1;
         in_sig    = ~in_sig;
         in_sticky = ~in_sticky;
      end
   endtask

   task automatic expect_out(input string tag, input logic [WIDTH-1:0] r,
                             input logic ix, input logic iv);
      n_chk++;
      if (out_result !== r || out_inexact !== ix || out_invalid !== iv) begin
         n_bad++;
         $display("FAIL %s: got %h inx=%b inv=%b, expected %h inx=%b inv=%b",
                  tag, out_result, out_inexact, out_invalid, r, ix, iv);
      end
   endtask

   // Monitor: compares each output against the head of the scoreboard.
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (out_valid) begin
            if (sbq.size() == 0) begin
               n_chk++; n_bad++;
               $display("FAIL R1: out_valid with no pending operand, got 1 expected 0");
            end else begin
               item_t it;
               it = sbq.pop_front();
               n_chk++;
               if (it.due != cyc) begin
                  n_bad++;
                  $display("FAIL R1: result in cycle %0d, expected cycle %0d", cyc, it.due);
               end
               expect_out(it.tag, it.res, it.inx, it.inv);
            end
         end else if (sbq.size() > 0 && sbq[0].due <= cyc) begin
            n_chk++; n_bad++;
            $display("FAIL R1: out_valid low in cycle %0d, expected high (due %0d)",
                     cyc, sbq[0].due);
            void'(sbq.pop_front());
         end
      end
   end

   localparam logic [SIG_W-1:0] PAT   = 64'hD555_5555_5555_5555;
   localparam logic [SIG_W-1:0] ONE   = 64'h8000_0000_0000_0000;
   localparam logic [SIG_W-1:0] ONEP  = 64'h8000_0000_0000_0001;
   localparam logic [SIG_W-1:0] ALL1  = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam logic [SIG_W-1:0] FIVE8 = 64'hA000_0000_0000_0000;

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) begin
         n_bad++; $display("FAIL R10: reset out_valid %b expected 0", out_valid);
      end
      expect_out("R10 reset", '0, 1'b0, 1'b0);
      rst_n = 1'b1;

      // Zero class, arbitrary other fields
      apply(1'b0, 3'd0, 7,  PAT, 1'b1, 1'b1, 1'b1, "R2");
      apply(1'b1, 3'd0, 40, ALL1, 1'b0, 1'b1, 1'b0, "R2");

      // Exponent sweep, both signs, back to back
      for (int e = -3; e <= WIDTH + 1; e++) begin
         string t;
         t = (e < 0) ? "R5" : (e >= WIDTH) ? "R6" : (e == WIDTH - 1) ? "R7" : "R3";
         apply(1'b0, 3'd1, e, PAT, e[0], 1'b0, 1'b0, t);
         apply(1'b1, 3'd1, e, PAT, 1'b0, e[1], 1'b0, t);
      end

      // Exact values and single dropped bits
      apply(1'b0, 3'd1, 5, FIVE8, 1'b0, 1'b0, 1'b0, "R4 exact 40");
      apply(1'b1, 3'd1, 5, FIVE8, 1'b0, 1'b0, 1'b0, "R4 exact -40");
      apply(1'b0, 3'd1, 5, FIVE8, 1'b0, 1'b0, 1'b1, "R4 sticky only");
      apply(1'b1, 3'd1, 5, FIVE8, 1'b1, 1'b0, 1'b0, "R4 guard only");
      apply(1'b0, 3'd1, 0, ONE,   1'b0, 1'b0, 1'b0, "R4 exact 1");
      apply(1'b1, 3'd1, 0, 64'hC000_0000_0000_0000, 1'b0, 1'b0, 1'b0, "R3 -1.5");
      apply(1'b0, 3'd1, -1, ONE, 1'b0, 1'b0, 1'b0, "R5 half");

      // Boundary magnitude 2^(WIDTH-1)
      apply(1'b1, 3'd1, WIDTH - 1, ONE,  1'b0, 1'b0, 1'b0, "R7 min int");
      apply(1'b0, 3'd1, WIDTH - 1, ONE,  1'b0, 1'b0, 1'b0, "R7 +edge");
      apply(1'b1, 3'd1, WIDTH - 1, ONEP, 1'b0, 1'b0, 1'b0, "R7 min int inexact");
      apply(1'b0, 3'd1, WIDTH - 2, ALL1, 1'b0, 1'b0, 1'b0, "R7 max int");
      apply(1'b1, 3'd1, WIDTH - 2, ALL1, 1'b1, 1'b1, 1'b1, "R7 -max int");
      apply(1'b1, 3'd1, 200, ONE, 1'b0, 1'b0, 1'b0, "R6 far");

      // Non-number and unused class codes
      for (int c = 2; c < 8; c++) begin
         apply(1'b0, 3'(c), 3, PAT, 1'b1, 1'b1, 1'b1, "R8 R9 pos");
         apply(1'b1, 3'(c), 3, PAT, 1'b1, 1'b0, 1'b1, "R8 R9 neg");
      end

      idle(1);
      wait (sbq.size() == 0);
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) begin
         n_bad++; $display("FAIL R1: idle out_valid %b expected 0", out_valid);
      end
      expect_out("R10 hold", last_item.res, last_item.inx, last_item.inv);
      idle(4);
      @(negedge clk);
      expect_out("R10 hold after scramble", last_item.res, last_item.inx, last_item.inv);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule